// File: doc/BRIEF.md
# Reconfiguration Handshake Slave

This block lives inside a reconfigurable core that carries its own small embedded processor. A central reconfiguration controller owns one request strobe per core. When the strobe for this core arrives, the block grants or refuses the request. A refusal happens when embedded software has switched reconfiguration off through two dedicated instructions: one enables it and one disables it. Software uses this to protect time slots in which the core must not be replaced.

A grant raises the acknowledge. The acknowledge also takes the core off the on-chip bus. A hold output freezes the processor: the program counter stops, program-memory fetches are blocked, and the core's interfaces go unserviced. Both outputs stay high until the external configuration rewrite reports completion with a one-cycle done pulse. Execution resumes on the next clock. Two elaboration options can issue a one-cycle clear of the program counter and of the stack pointer at that moment, so that a new software context starts from a known point. A refused request is not remembered, and the controller is expected to retry it.

Top module: `reconf_slave_if`

## Requirements
- R1: While `rst_n` is low and after reset, `reconf_ack`, `cpu_hold`, `pc_clear` and `sp_clear` are 0. `reconf_en` equals parameter `EN_AT_RESET`, which defaults to 1.
- R2: While not frozen, a high `sw_en_set` makes `reconf_en` 1 from the next edge and a high `sw_en_clr` makes it 0. If both are high, the clear wins.
- R3: With `reconf_ack` low, a high `reconf_req_stb` while `reconf_en` is 1 makes `reconf_ack` 1 from the next clock edge. The flag value used is the one held before that edge.
- R4: A strobe seen while `reconf_en` is 0 gives no acknowledge and is not stored: `reconf_ack` stays 0 in the cycles after it.
- R5: Once high, `reconf_ack` stays high until `reconf_done` is seen. Further strobes during that time have no effect.
- R6: While `reconf_ack` is high, `sw_en_set` and `sw_en_clr` are ignored, so `reconf_en` keeps its value.
- R7: A `reconf_done` seen while `reconf_ack` is high drops `reconf_ack` on the next edge. A `reconf_done` while idle has no effect, even in the same cycle as a strobe.
- R8: With `PC_CLR_ON_RESUME`=1, `pc_clear` is 1 for exactly the one cycle that follows the done edge, and is 0 at all other times. With the default 0, it is never 1.
- R9: `SP_CLR_ON_RESUME` governs `sp_clear` in the same way as R8 describes for `pc_clear`.
- R10: `cpu_hold` equals `reconf_ack` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_en_set | input | 1 | Enable instruction executed (allow reconfiguration) |
| sw_en_clr | input | 1 | Disable instruction executed (forbid reconfiguration) |
| reconf_req_stb | input | 1 | Request strobe from the central controller |
| reconf_done | input | 1 | One-cycle pulse: configuration rewrite finished |
| reconf_ack | output | 1 | Acknowledge to controller; also detaches the core from the bus |
| cpu_hold | output | 1 | Freezes program counter and program-memory access |
| reconf_en | output | 1 | Current reconfiguration-enable flag |
| pc_clear | output | 1 | One-cycle program counter clear on resume |
| sp_clear | output | 1 | One-cycle stack pointer clear on resume |

## Verification
The grant path is tried with four kinds of strobe:
- a strobe with the flag on, which separates a grant from a refusal;
- a strobe with the flag off and then silence, which shows the request was not stored;
- a strobe in the same cycle as an enable instruction, which shows the decision uses the old flag value;
- strobes while frozen, which separate a held freeze from a re-armed one.

The release path is tried with several done patterns:
- done while idle, alone and together with a strobe, which shows idle done pulses are ignored;
- done together with a strobe while frozen, which shows the release takes priority.

Set and clear instructions are issued while frozen, and also together, to expose an enable flag that is not gated or a clear that does not win. Two instances, one with the resume options off and one with them on, show that each clear pulse appears only when its option is on, and only in the cycle after release.

// File: rtl/rhs_pkg.sv
`timescale 1ns/1ps
package rhs_pkg;
   typedef enum logic {
      ST_RUN    = 1'b0,
      ST_FROZEN = 1'b1
   } rhs_state_e;
endpackage

// File: rtl/rhs_enable_flag.sv
`timescale 1ns/1ps
module rhs_enable_flag #(
   parameter int unsigned EN_AT_RESET = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic frozen_i,
   output logic en_o
);
   localparam logic RST_VAL = (EN_AT_RESET != 0);

   logic en_q;

   // Software cannot run while frozen, so instruction strobes are dropped.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= RST_VAL;
      else if (!frozen_i) begin
         if (clr_i)
            en_q <= 1'b0;
         else if (set_i)
            en_q <= 1'b1;
      end
   end

   assign en_o = en_q;

   AST_FLAG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      frozen_i |=> $stable(en_q)); // R6
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!frozen_i && clr_i) |=> !en_q); // R2
   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (!frozen_i && set_i && !clr_i) |=> en_q); // R2
endmodule

// File: rtl/rhs_freeze_fsm.sv
`timescale 1ns/1ps
module rhs_freeze_fsm
   import rhs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic done_i,
   input  logic en_i,
   output logic ack_o,
   output logic hold_o,
   output logic frozen_o
);
   rhs_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:    if (req_i && en_i) state_d = ST_FROZEN;
         ST_FROZEN: if (done_i)        state_d = ST_RUN;
         default:                      state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= ST_RUN;
      else
         state_q <= state_d;
   end

   assign frozen_o = (state_q == ST_FROZEN);
   assign ack_o    = frozen_o;
   assign hold_o   = frozen_o;

   AST_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_o && req_i && en_i) |=> ack_o); // R3
   AST_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_o && !(req_i && en_i)) |=> !ack_o); // R4
   AST_HOLD_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && !done_i) |=> ack_o); // R5
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && done_i) |=> !ack_o); // R7
endmodule

// File: rtl/rhs_resume_clear.sv
`timescale 1ns/1ps
module rhs_resume_clear #(
   parameter int unsigned ENABLE = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frozen_i,
   input  logic done_i,
   output logic clr_o
);
   generate
      if (ENABLE != 0) begin : g_on
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pulse_q <= 1'b0;
            else
               pulse_q <= frozen_i && done_i;
         end
         assign clr_o = pulse_q;

         AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_q |=> !pulse_q); // R8, R9
         AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_q |-> ($past(frozen_i) && $past(done_i) && !frozen_i)); // R8, R9
      end else begin : g_off
         assign clr_o = 1'b0;
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ frozen_i ^ done_i;
      end
   endgenerate
endmodule

// File: rtl/reconf_slave_if.sv
`timescale 1ns/1ps
module reconf_slave_if #(
   parameter int unsigned EN_AT_RESET      = 1,
   parameter int unsigned PC_CLR_ON_RESUME = 0,
   parameter int unsigned SP_CLR_ON_RESUME = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_en_set,
   input  logic sw_en_clr,
   input  logic reconf_req_stb,
   input  logic reconf_done,
   output logic reconf_ack,
   output logic cpu_hold,
   output logic reconf_en,
   output logic pc_clear,
   output logic sp_clear
);
   generate
      if (EN_AT_RESET > 1) begin : g_bad_en
         $error("EN_AT_RESET must be 0 or 1");
      end
      if (PC_CLR_ON_RESUME > 1) begin : g_bad_pc
         $error("PC_CLR_ON_RESUME must be 0 or 1");
      end
      if (SP_CLR_ON_RESUME > 1) begin : g_bad_sp
         $error("SP_CLR_ON_RESUME must be 0 or 1");
      end
   endgenerate

   logic frozen;
   logic en_flag;

   rhs_enable_flag #(.EN_AT_RESET(EN_AT_RESET)) u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(sw_en_set), .clr_i(sw_en_clr),
      .frozen_i(frozen), .en_o(en_flag)
   );

   rhs_freeze_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .req_i(reconf_req_stb), .done_i(reconf_done),
      .en_i(en_flag), .ack_o(reconf_ack), .hold_o(cpu_hold), .frozen_o(frozen)
   );

   rhs_resume_clear #(.ENABLE(PC_CLR_ON_RESUME)) u_pc_clr (
      .clk(clk), .rst_n(rst_n), .frozen_i(frozen), .done_i(reconf_done),
      .clr_o(pc_clear)
   );

   rhs_resume_clear #(.ENABLE(SP_CLR_ON_RESUME)) u_sp_clr (
      .clk(clk), .rst_n(rst_n), .frozen_i(frozen), .done_i(reconf_done),
      .clr_o(sp_clear)
   );

   assign reconf_en = en_flag;

   AST_HOLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hold == reconf_ack); // R10
   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |-> (!reconf_ack && !pc_clear && !sp_clear)); // R1
endmodule

// File: tb/sim_reconf_slave_if.sv
`timescale 1ns/1ps
module sim_reconf_slave_if;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic set_s = 1'b0, clr_s = 1'b0, req_s = 1'b0, done_s = 1'b0;
   logic ack0, hold0, en0, pcc0, spc0;
   logic ack1, hold1, en1, pcc1, spc1;
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   reconf_slave_if u0 (
      .clk(clk), .rst_n(rst_n), .sw_en_set(set_s), .sw_en_clr(clr_s),
      .reconf_req_stb(req_s), .reconf_done(done_s), .reconf_ack(ack0),
      .cpu_hold(hold0), .reconf_en(en0), .pc_clear(pcc0), .sp_clear(spc0)
   );

   reconf_slave_if #(.PC_CLR_ON_RESUME(1), .SP_CLR_ON_RESUME(1)) u1 (
      .clk(clk), .rst_n(rst_n), .sw_en_set(set_s), .sw_en_clr(clr_s),
      .reconf_req_stb(req_s), .reconf_done(done_s), .reconf_ack(ack1),
      .cpu_hold(hold1), .reconf_en(en1), .pc_clear(pcc1), .sp_clear(spc1)
   );

   // {set, clr, req, done, exp_en, exp_ack, exp_resume}
   localparam int NV = 20;
   localparam logic [6:0] VEC [NV] = '{
      7'b0000_100, // idle
      7'b0010_110, // R3 grant
      7'b0000_110, // R5 held
      7'b0010_110, // R5 strobe while frozen
      7'b0100_110, // R6 clear ignored while frozen
      7'b0001_101, // R7 release, R8 R9 pulse
      7'b0000_100, // R8 pulse single
      7'b0100_000, // R2 clear
      7'b0010_000, // R4 veto
      7'b0000_000, // R4 not stored
      7'b0001_000, // R7 idle done ignored
      7'b1000_100, // R2 set
      7'b1100_000, // R2 clear wins
      7'b1010_100, // R3 old flag used
      7'b0010_110, // R3 grant
      7'b0011_101, // R7 done beats strobe
      7'b0000_100,
      7'b0011_110, // R7 done ignored when idle
      7'b0001_101, // R7 release
      7'b0000_100
   };

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input logic s, input logic c, input logic r, input logic d);
      @(negedge clk);
      set_s = s; clr_s = c; req_s = r; done_s = d;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #100000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 ack in reset", ack0, 1'b0);
      chk("R1 hold in reset", hold0, 1'b0);
      chk("R1 pc_clear in reset", pcc1, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 flag after reset", en0, 1'b1);
      chk("R1 ack after reset", ack0, 1'b0);
      chk("R1 sp_clear after reset", spc1, 1'b0);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
         chk($sformatf("R2/R6 flag row %0d", i), en0, VEC[i][2]);
         chk($sformatf("R3/R4/R5/R7 ack row %0d", i), ack0, VEC[i][1]);
         chk($sformatf("R10 hold row %0d", i), hold0, ack0);
         chk($sformatf("R8 pc_clear on row %0d", i), pcc1, VEC[i][0]);
         chk($sformatf("R9 sp_clear on row %0d", i), spc1, VEC[i][0]);
         chk($sformatf("R8 pc_clear off row %0d", i), pcc0, 1'b0);
         chk($sformatf("R9 sp_clear off row %0d", i), spc0, 1'b0);
         chk($sformatf("R5 options ack match row %0d", i), ack1, ack0);
      end

      // Reset while frozen returns to idle (R1)
      step(1'b0, 1'b0, 1'b1, 1'b0);
      chk("R3 grant before reset", ack0, 1'b1);
      @(negedge clk);
      req_s = 1'b0;
      rst_n = 1'b0;
      #1;
      chk("R1 ack drops in reset", ack0, 1'b0);
      chk("R10 hold drops in reset", hold1, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 1'b0, 1'b0, 1'b0);
      chk("R1 no stale freeze", ack0, 1'b0);
      chk("R1 no clear after reset", pcc1, 1'b0);

      // Long freeze: several idle cycles keep it held (R5)
      step(1'b0, 1'b0, 1'b1, 1'b0);
      for (int k = 0; k < 8; k++) begin
         step(1'b0, 1'b0, 1'b0, 1'b0);
         chk("R5 long hold", ack0, 1'b1);
      end
      step(1'b1, 1'b1, 1'b0, 1'b1);
      chk("R7 release after long hold", ack0, 1'b0);
      chk("R6 strobes in release cycle ignored", en0, 1'b1);
      chk("R8 pc clear after long hold", pcc1, 1'b1);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      chk("R9 sp clear single cycle", spc1, 1'b0);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule